// File: doc/BRIEF.md
# Armed Multi-Source Level Trigger

This block decides when an acquisition starts. It watches the sample streams of six acquisition channels, two external trigger lines (a standard one and a high-speed one) and a software force strobe. Once armed, it emits exactly one trigger pulse when the selected source meets its condition, then disarms and holds a sticky triggered flag until it is armed again.

Channel samples and the threshold are both 12-bit offset-binary codes. Code 0x800 stands for zero volts, 0x000 for negative full scale and 0xFFF for positive full scale, so the block compares them as plain unsigned numbers. A small register port holds the source select, the slope bit and the threshold. Separate one-cycle command strobes arm the unit and force a trigger.

Top module: `lvl_trig_top`

## Requirements
- R1: After reset, both registers read 0, and `armed`, `triggered` and `trig_pulse` are 0.
- R2: The control register sits at address 0. Bits [2:0] hold the source select and bit 3 holds the slope, and every other bit reads 0. The threshold register sits at address 1. Bits [11:0] hold the threshold, and bits [15:12] read 0. A write with `reg_wr` high is visible on `reg_rdata` in the next cycle.
- R3: Source codes 0 to 5 select channels 0 to 5. Code 6 selects the standard external line and code 7 selects the high-speed external line. A source that is not selected never fires the trigger.
- R4: With slope 0, a channel fires when its previous valid sample is unsigned-below the threshold and its current valid sample is at or above it. The pulse appears in the cycle after the crossing sample.
- R5: With slope 1, channels 0 to 3 fire when the previous valid sample is above the threshold and the current one is at or below it. With slope 1, a rising crossing on these channels does not fire.
- R6: Channels 4 and 5 fire on a rising crossing only, whatever the slope bit says.
- R7: Each external line passes through a two-flop synchroniser and fires on its rising edge. An input first sampled high at clock edge k gives `trig_pulse` high after edge k+2. A line held high fires only once.
- R8: `force_cmd` fires the trigger while the unit is armed, whatever source is selected. It has no effect while the unit is disarmed.
- R9: No source fires while the unit is disarmed.
- R10: On a fire, `trig_pulse` is high for exactly one cycle, `triggered` becomes 1 and `armed` becomes 0. No further pulse follows until the unit is re-armed.
- R11: `arm_cmd` sets `armed` to 1, clears `triggered` and clears every channel's crossing history. The first valid sample after arming therefore cannot complete a crossing.
- R12: A control write that changes the source select while the unit is armed clears every channel's crossing history.
- R13: When `arm_cmd` coincides with a fire condition, arming wins. No pulse is produced and the unit stays armed with `triggered` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 for control, 1 for threshold |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Read data of the register chosen by `reg_addr` |
| arm_cmd | input | 1 | One-cycle arm command |
| force_cmd | input | 1 | One-cycle software force-trigger command |
| smp_data | input | 72 | Six 12-bit offset-binary samples; channel i sits in bits [12i+11:12i] |
| smp_vld | input | 6 | Per-channel sample valid |
| ext_std | input | 1 | Asynchronous standard external trigger line |
| ext_fast | input | 1 | Asynchronous high-speed external trigger line |
| trig_pulse | output | 1 | One-cycle trigger pulse |
| armed | output | 1 | Unit is armed |
| triggered | output | 1 | Sticky flag: a trigger has fired since the last arm |

## Verification
The bench builds the block with its default parameters: six channels of 12 bits, four slope-capable channels and a two-stage synchroniser. With these values the source field has exactly eight codes. The bench therefore sweeps every source code against a stimulus on every one of the eight sources, under both slope settings and both crossing directions. The expected fire decision is computed from the requirement rules for each combination. Directed cases add the threshold extremes 0x000 and 0xFFF, the exact external latency, and the ordering of arm, force and source change against a pending crossing.

// File: rtl/lvl_trig_pkg.sv
`timescale 1ns/1ps
// Package: shared encodings of the level trigger.
// Assumes a single-bit register address space.
package lvl_trig_pkg;
    typedef enum logic {
        REG_CTRL = 1'b0,
        REG_THR  = 1'b1
    } reg_sel_e;

    typedef enum logic {
        DIR_RISE = 1'b0,
        DIR_FALL = 1'b1
    } dir_e;
endpackage

// File: rtl/lvl_trig_regs.sv
`timescale 1ns/1ps
// Module: register file that holds the source select, the slope bit and the threshold.
// Assumes the bus decode above it delivers single-cycle write strobes.
// Also reports a write that changes the source select.
module lvl_trig_regs
    import lvl_trig_pkg::*;
#(
    parameter int SW    = 12,
    parameter int SRC_W = 3,
    parameter int RW    = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic             addr,
    input  logic [RW-1:0]    wdata,
    output logic [RW-1:0]    rdata,
    output logic [SRC_W-1:0] src,
    output logic             slope,
    output logic [SW-1:0]    thr,
    output logic             src_chg
);
    logic unused_wbits;
    assign unused_wbits = ^wdata[RW-1:SW];

    // Capture register writes and reset every field to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src   <= '0;
            slope <= 1'b0;
            thr   <= '0;
        end else if (wr) begin
            if (addr == REG_CTRL) begin
                src   <= wdata[SRC_W-1:0];
                slope <= wdata[SRC_W];
            end else begin
                thr <= wdata[SW-1:0];
            end
        end
    end

    // Flag a control write whose source field differs from the current one.
    assign src_chg = wr && (addr == REG_CTRL) && (wdata[SRC_W-1:0] != src);

    // Return the selected register, padded with zeros.
    always_comb begin
        rdata = '0;
        if (addr == REG_CTRL) begin
            rdata[SRC_W-1:0] = src;
            rdata[SRC_W]     = slope;
        end else begin
            rdata[SW-1:0] = thr;
        end
    end

    assert_thr_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_THR) |=> (thr == $past(wdata[SW-1:0])));
    assert_ctrl_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == REG_CTRL) |=> (src == $past(wdata[SRC_W-1:0]) && slope == $past(wdata[SRC_W])));
endmodule

// File: rtl/lvl_trig_cross.sv
`timescale 1ns/1ps
// Module: threshold crossing detector for one channel.
// Assumes offset-binary samples, so an unsigned compare against the threshold is enough.
// Keeps the last valid sample as history, and clr discards it.
module lvl_trig_cross
    import lvl_trig_pkg::*;
#(
    parameter int SW        = 12,
    parameter bit HAS_SLOPE = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          vld,
    input  logic [SW-1:0] smp,
    input  logic [SW-1:0] thr,
    input  logic          slope,
    output logic          hit
);
    logic [SW-1:0] prev;
    logic          hv;
    logic          falling;
    logic          cond;

    // Store the last valid sample, or drop the history on clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            hv   <= 1'b0;
        end else if (clr) begin
            hv <= 1'b0;
        end else if (vld) begin
            prev <= smp;
            hv   <= 1'b1;
        end
    end

    // Pick the crossing direction; channels without a slope option always rise.
    assign falling = HAS_SLOPE && (slope == DIR_FALL);

    // Compare the previous and current samples against the threshold.
    always_comb begin
        if (falling) cond = (prev > thr) && (smp <= thr);
        else         cond = (prev < thr) && (smp >= thr);
    end

    assign hit = hv && vld && !clr && cond;

    assert_clr_drops_hist_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !hv);
endmodule

// File: rtl/lvl_trig_xsync.sv
`timescale 1ns/1ps
// Module: synchroniser and rising-edge detector for an asynchronous trigger line.
// Assumes the line stays high or low for at least one clock period.
module lvl_trig_xsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES:0] sr;

    // Shift the line through the synchroniser plus one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sr <= '0;
        else        sr <= {sr[STAGES-1:0], din};
    end

    assign rise = sr[STAGES-1] && !sr[STAGES];

    assert_rise_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);
endmodule

// File: rtl/lvl_trig_top.sv
`timescale 1ns/1ps
// Module: armed multi-source level trigger.
// Chooses one of the channels or external lines as the source. Once armed, it fires one
// trigger pulse on that source's condition or on a software force, then disarms.
// Assumes arm_cmd and force_cmd are single-cycle strobes in the clk domain.
module lvl_trig_top #(
    parameter int NCH    = 6,
    parameter int SW     = 12,
    parameter int NLOW   = 4,
    parameter int SYNC   = 2,
    parameter int RW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [RW-1:0]     reg_wdata,
    output logic [RW-1:0]     reg_rdata,
    input  logic              arm_cmd,
    input  logic              force_cmd,
    input  logic [NCH*SW-1:0] smp_data,
    input  logic [NCH-1:0]    smp_vld,
    input  logic              ext_std,
    input  logic              ext_fast,
    output logic              trig_pulse,
    output logic              armed,
    output logic              triggered
);
    localparam int NEXT  = 2;
    localparam int NSRC  = NCH + NEXT;
    localparam int SRC_W = $clog2(NSRC);
    localparam int NCODE = 1 << SRC_W;

    logic [SRC_W-1:0] src;
    logic             slope;
    logic [SW-1:0]    thr;
    logic             src_chg;
    logic             hist_clr;
    logic [NSRC-1:0]  hit_vec;
    logic [NCODE-1:0] hit_all;
    logic [NEXT-1:0]  ext_in;
    logic             sel_hit;

    lvl_trig_regs #(.SW(SW), .SRC_W(SRC_W), .RW(RW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
        .rdata(reg_rdata), .src(src), .slope(slope), .thr(thr), .src_chg(src_chg)
    );

    // Clear crossing history on arm, or on a source change while armed.
    assign hist_clr = arm_cmd || (src_chg && armed);

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        lvl_trig_cross #(.SW(SW), .HAS_SLOPE(i < NLOW)) u_cross (
            .clk(clk), .rst_n(rst_n), .clr(hist_clr), .vld(smp_vld[i]),
            .smp(smp_data[i*SW +: SW]), .thr(thr), .slope(slope), .hit(hit_vec[i])
        );
    end

    assign ext_in = {ext_fast, ext_std};

    for (genvar j = 0; j < NEXT; j++) begin : g_ext
        lvl_trig_xsync #(.STAGES(SYNC)) u_sync (
            .clk(clk), .rst_n(rst_n), .din(ext_in[j]), .rise(hit_vec[NCH+j])
        );
    end

    // Select the hit of the chosen source; unused codes never hit.
    assign hit_all = NCODE'(hit_vec);
    assign sel_hit = hit_all[src];

    // Arm, fire and disarm sequencing; arming wins over a simultaneous fire.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            triggered  <= 1'b0;
            trig_pulse <= 1'b0;
        end else begin
            trig_pulse <= 1'b0;
            if (arm_cmd) begin
                armed     <= 1'b1;
                triggered <= 1'b0;
            end else if (armed && (sel_hit || force_cmd)) begin
                armed      <= 1'b0;
                triggered  <= 1'b1;
                trig_pulse <= 1'b1;
            end
        end
    end

    assert_pulse_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |=> !trig_pulse);
    assert_fire_disarms_R10: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> (!armed && triggered));
    assert_pulse_needs_arm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        trig_pulse |-> $past(armed));
    assert_arm_wins_R13: assert property (@(posedge clk) disable iff (!rst_n)
        arm_cmd |=> (armed && !triggered && !trig_pulse));
endmodule

// File: tb/sim_lvl_trig_top.sv
`timescale 1ns/1ps
module sim_lvl_trig_top;
    localparam int NCH = 6;
    localparam int SW  = 12;
    localparam int RW  = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_wr = 1'b0;
    logic              reg_addr = 1'b0;
    logic [RW-1:0]     reg_wdata = '0;
    logic [RW-1:0]     reg_rdata;
    logic              arm_cmd = 1'b0;
    logic              force_cmd = 1'b0;
    logic [NCH*SW-1:0] smp_data = '0;
    logic [NCH-1:0]    smp_vld = '0;
    logic              ext_std = 1'b0;
    logic              ext_fast = 1'b0;
    logic              trig_pulse;
    logic              armed;
    logic              triggered;

    int nchk = 0;
    int nfail = 0;
    int pcount = 0;
    bit done = 1'b0;

    lvl_trig_top u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .arm_cmd(arm_cmd),
        .force_cmd(force_cmd), .smp_data(smp_data), .smp_vld(smp_vld),
        .ext_std(ext_std), .ext_fast(ext_fast), .trig_pulse(trig_pulse),
        .armed(armed), .triggered(triggered)
    );

    always #2.5 clk = ~clk;

    // Count trigger pulses 1 ns after each rising edge.
    always @(posedge clk) begin
        #1;
        if (trig_pulse) pcount++;
    end

    task automatic tick(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic a, input logic [RW-1:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic a, output logic [RW-1:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic arm();
        arm_cmd = 1'b1;
        tick();
        arm_cmd = 1'b0;
        pcount = 0;
    endtask

    task automatic set_ch(input int i, input logic [SW-1:0] v);
        smp_data[i*SW +: SW] = v;
    endtask

    task automatic set_all(input logic [SW-1:0] v);
        for (int i = 0; i < NCH; i++) set_ch(i, v);
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(5.0 * 150000);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [RW-1:0] rd;
        logic [SW-1:0] th;
        tick(3);
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd_reg(1'b0, rd);
        chk(rd == 0, "R1 ctrl after reset", rd, 0);
        rd_reg(1'b1, rd);
        chk(rd == 0, "R1 thr after reset", rd, 0);
        chk({armed, triggered, trig_pulse} == 3'b000, "R1 flags after reset",
            {armed, triggered, trig_pulse}, 0);

        // R2: readback and masking
        wr_reg(1'b0, 16'hFFFF);
        rd_reg(1'b0, rd);
        chk(rd == 16'h000F, "R2 ctrl mask", rd, 16'h000F);
        wr_reg(1'b1, 16'hFFFF);
        rd_reg(1'b1, rd);
        chk(rd == 16'h0FFF, "R2 thr mask", rd, 16'h0FFF);
        wr_reg(1'b0, 16'h000A);
        rd_reg(1'b0, rd);
        chk(rd == 16'h000A, "R2 ctrl value", rd, 16'h000A);

        th = 12'h900;
        wr_reg(1'b1, {4'h0, th});
        wr_reg(1'b0, 16'h0000);
        smp_vld = '1;
        set_all(th - 1);
        tick(2);

        // R9: crossing while disarmed is ignored
        pcount = 0;
        set_ch(0, th);
        tick(3);
        chk(pcount == 0 && !triggered, "R9 disarmed crossing", pcount, 0);
        set_ch(0, th - 1);
        tick(2);

        // R8: force while disarmed has no effect
        pcount = 0;
        force_cmd = 1'b1; tick(); force_cmd = 1'b0; tick(2);
        chk(pcount == 0 && !triggered, "R8 force disarmed", pcount, 0);

        // R8: force while armed fires regardless of source
        wr_reg(1'b0, 16'h0006);
        arm();
        chk(armed && !triggered, "R11 arm sets armed", {armed, triggered}, 2'b10);
        force_cmd = 1'b1; tick(); force_cmd = 1'b0; tick(2);
        chk(pcount == 1 && triggered && !armed, "R8 force armed", pcount, 1);

        // R10: no further pulse until re-armed
        pcount = 0;
        force_cmd = 1'b1; tick(); force_cmd = 1'b0;
        ext_std = 1'b1; tick(5); ext_std = 1'b0; tick(3);
        chk(pcount == 0 && triggered && !armed, "R10 single shot", pcount, 0);

        // R11: arm clears flag and history
        wr_reg(1'b0, 16'h0000);
        set_ch(0, th - 1);
        tick();
        smp_vld[0] = 1'b0;
        arm();
        chk(!triggered && armed, "R11 arm clears flag", triggered, 0);
        set_ch(0, th); smp_vld[0] = 1'b1;
        tick(3);
        chk(pcount == 0, "R11 history cleared by arm", pcount, 0);

        // R12: source change while armed clears history
        set_ch(0, th - 1);
        wr_reg(1'b0, 16'h0001);
        arm();
        tick(2);
        smp_vld[0] = 1'b0;
        wr_reg(1'b0, 16'h0000);
        set_ch(0, th); smp_vld[0] = 1'b1;
        tick(3);
        chk(pcount == 0 && armed, "R12 source change clears history", pcount, 0);

        // R13: arm wins over a simultaneous crossing
        set_ch(0, th - 1);
        tick(2);
        set_ch(0, th); arm_cmd = 1'b1;
        tick();
        arm_cmd = 1'b0; pcount = 0;
        tick(2);
        chk(pcount == 0 && armed && !triggered, "R13 arm beats fire", pcount, 0);
        set_ch(0, th - 1); tick(); set_ch(0, th); tick(2);
        chk(pcount == 1 && triggered, "R4 crossing after R13 case", pcount, 1);

        // R7: external latency of two sync stages plus the fire register
        wr_reg(1'b0, 16'h0006);
        set_all(th - 1);
        tick(2);
        arm();
        ext_std = 1'b1;
        tick(2);
        chk(pcount == 0, "R7 no early pulse", pcount, 0);
        tick();
        chk(pcount == 1, "R7 pulse after third edge", pcount, 1);
        tick(4);
        ext_std = 1'b0;
        tick(3);

        // R4/R5: threshold extremes
        wr_reg(1'b1, 16'h0FFF);
        wr_reg(1'b0, 16'h0000);
        set_ch(0, 12'hFFE);
        arm(); tick(2);
        set_ch(0, 12'hFFF); tick(2);
        chk(pcount == 1, "R4 rise to 0xFFF", pcount, 1);
        wr_reg(1'b1, 16'h0000);
        wr_reg(1'b0, 16'h0008);
        set_ch(0, 12'h001);
        arm(); tick(2);
        set_ch(0, 12'h000); tick(2);
        chk(pcount == 1, "R5 fall to 0x000", pcount, 1);
        wr_reg(1'b0, 16'h0000);
        set_ch(0, 12'h000);
        arm(); tick(2);
        set_ch(0, 12'hFFF); tick(2);
        chk(pcount == 0, "R4 nothing below 0x000", pcount, 0);

        // R3/R4/R5/R6/R7: sweep of source, stimulus, slope and direction
        wr_reg(1'b1, {4'h0, th});
        for (int s = 0; s < 8; s++) begin
            for (int st = 0; st < 8; st++) begin
                for (int sl = 0; sl < 2; sl++) begin
                    for (int d = 0; d < 2; d++) begin
                        bit exp_fire;
                        if (st >= NCH && d == 1) continue;
                        wr_reg(1'b0, RW'((sl << 3) | s));
                        set_all(th - 1);
                        if (st < NCH && d == 1) set_ch(st, th + 1);
                        tick(2);
                        arm();
                        tick(2);
                        if (st < NCH) set_ch(st, th);
                        else if (st == NCH) ext_std = 1'b1;
                        else ext_fast = 1'b1;
                        tick(5);
                        if (s != st) exp_fire = 1'b0;
                        else if (st < 4) exp_fire = (d == sl);
                        else if (st < NCH) exp_fire = (d == 0);
                        else exp_fire = 1'b1;
                        chk(pcount == int'(exp_fire) && triggered == exp_fire,
                            $sformatf("R3 R4 R5 R6 R7 src=%0d stim=%0d slope=%0d dir=%0d",
                                      s, st, sl, d),
                            pcount, int'(exp_fire));
                        ext_std = 1'b0; ext_fast = 1'b0;
                        set_all(th - 1);
                        tick(4);
                    end
                end
            end
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule